// File: doc/BRIEF.md
# Accelerator Start/Done Control Register

This block is the software-facing control and status register set of a frame-processing engine. It sits behind a small AXI4-Lite slave port. Through it software can launch a processing run, see whether the run has finished, see whether the engine is idle or ready for new input, and select a mode in which the engine is relaunched for every frame with no further writes from software.

On the engine side the block drives a single start request and takes three indications from the datapath: a one-cycle done pulse, a live idle level and a live ready level. The start bit clears itself once the engine has accepted it. The done bit clears itself when software reads it. The auto-restart bit keeps the start request asserted so that runs follow one another back to back. A global interrupt enable and an interrupt enable register can be written and read back, and an interrupt status register can be read, but none of them has any effect on the block's behaviour.

Top module: `accel_ctrl_regs`

## Requirements
- R1: After reset `eng_start` is low, both response channels are idle, all ready outputs are high, and every stored bit (start, done, auto-restart, interrupt enables) reads as 0.
- R2: A write to offset 0x00 with `s_wstrb[0]` high and data bit 0 high raises `eng_start` in the cycle after the write is committed, and bit 0 of offset 0x00 reads 1. A write with data bit 0 low leaves the start bit unchanged.
- R3: When `eng_start` and `eng_ready` are both high in a cycle and the auto-restart bit is 0, `eng_start` is low in the next cycle. `eng_start` never falls unless `eng_ready` was high in the cycle before.
- R4: Bit 7 of offset 0x00 is the auto-restart bit and can be written and read. While it is 1, `eng_start` stays high through every handshake. Once it is cleared, the next handshake drops `eng_start`.
- R5: A one-cycle `eng_done` pulse sets the done flag, which reads as bit 1 of offset 0x00 from the following cycle.
- R6: A read of offset 0x00 that returns bit 1 set clears the done flag. If `eng_done` is high in the cycle the read address is accepted, the flag stays set.
- R7: Bits 2 and 3 of offset 0x00 show `eng_idle` and `eng_ready` as they are in the cycle the read address is accepted.
- R8: Bit 0 at offset 0x04 and bits 1:0 at offset 0x08 read back the last value written to them. Offset 0x0C reads 0 and ignores writes. None of these registers changes `eng_start`.
- R9: Reserved bits (31:8 and 6:4 at 0x00, 31:1 at 0x04, 31:2 at 0x08) and all offsets from 0x10 upward read as 0.
- R10: Each channel handles one transaction at a time. `s_bresp` and `s_rresp` are always 00 (OKAY). `s_arready` is low while a read response is pending, and `s_rvalid` and `s_rdata` hold until `s_rready` is high.
- R11: A write with `s_wstrb[0]` low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| eng_start | output | 1 | Start request to the engine |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_idle | input | 1 | Engine idle level |
| eng_ready | input | 1 | Engine ready to accept a start |

## Verification
On every cycle the assertions check the start bit: it rises after a start write, it drops after a handshake when auto-restart is off, it holds through handshakes when auto-restart is on, and it never falls without a handshake. They also check that the done flag is set by a pulse, is cleared by a read only when no pulse arrives in the same cycle, and otherwise holds, that reserved read bits are zero and that pending responses hold. Only the bench scenarios can show the full software-visible picture. These are the exact read values across every idle/ready combination, the read-back of the inert interrupt registers, zero data from unmapped offsets, the effect of a clear byte strobe and a long auto-restart run ended by clearing the mode.

// File: rtl/accel_ctrl_regs.sv
module accel_ctrl_regs #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     s_awaddr,
  input  logic                  s_awvalid,
  output logic                  s_awready,
  input  logic [DATA_W-1:0]     s_wdata,
  input  logic [DATA_W/8-1:0]   s_wstrb,
  input  logic                  s_wvalid,
  output logic                  s_wready,
  output logic [1:0]            s_bresp,
  output logic                  s_bvalid,
  input  logic                  s_bready,
  input  logic [ADDR_W-1:0]     s_araddr,
  input  logic                  s_arvalid,
  output logic                  s_arready,
  output logic [DATA_W-1:0]     s_rdata,
  output logic [1:0]            s_rresp,
  output logic                  s_rvalid,
  input  logic                  s_rready,
  output logic                  eng_start,
  input  logic                  eng_done,
  input  logic                  eng_idle,
  input  logic                  eng_ready
);

  localparam int IDX_W  = ADDR_W - 2;
  localparam int STRB_W = DATA_W / 8;
  localparam logic [IDX_W-1:0] W_CTRL = IDX_W'(0);
  localparam logic [IDX_W-1:0] W_GIE  = IDX_W'(1);
  localparam logic [IDX_W-1:0] W_IER  = IDX_W'(2);
  localparam logic [IDX_W-1:0] W_ISR  = IDX_W'(3);

  logic             aw_got, w_got, bvalid_q, rvalid_q;
  logic [IDX_W-1:0] aw_idx_q;
  logic [7:0]       w_byte_q;
  logic             w_en_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  logic             start_q, done_q, auto_q, gie_q;
  logic [1:0]       ier_q;

  logic unused_bits;
  assign unused_bits = ^{s_awaddr[1:0], s_araddr[1:0], s_wdata[DATA_W-1:8], s_wstrb[STRB_W-1:1]};

  // write channel
  assign s_awready = ~aw_got & ~bvalid_q;
  assign s_wready  = ~w_got & ~bvalid_q;
  assign s_bvalid  = bvalid_q;
  assign s_bresp   = 2'b00;

  logic aw_fire, w_fire, wr_go, wr_lo, wr_ctrl, set_start;
  assign aw_fire   = s_awvalid & s_awready;
  assign w_fire    = s_wvalid & s_wready;
  assign wr_go     = aw_got & w_got & ~bvalid_q;
  assign wr_lo     = wr_go & w_en_q;
  assign wr_ctrl   = wr_lo && (aw_idx_q == W_CTRL);
  assign set_start = wr_ctrl & w_byte_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_got   <= 1'b0;
      w_got    <= 1'b0;
      bvalid_q <= 1'b0;
      aw_idx_q <= '0;
      w_byte_q <= '0;
      w_en_q   <= 1'b0;
    end else begin
      if (aw_fire) begin
        aw_got   <= 1'b1;
        aw_idx_q <= s_awaddr[ADDR_W-1:2];
      end
      if (w_fire) begin
        w_got    <= 1'b1;
        w_byte_q <= s_wdata[7:0];
        w_en_q   <= s_wstrb[0];
      end
      if (wr_go) begin
        aw_got   <= 1'b0;
        w_got    <= 1'b0;
        bvalid_q <= 1'b1;
      end else if (bvalid_q && s_bready) begin
        bvalid_q <= 1'b0;
      end
    end
  end

  // control state
  logic handshake;
  assign handshake = start_q & eng_ready;
  assign eng_start = start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      auto_q  <= 1'b0;
      gie_q   <= 1'b0;
      ier_q   <= 2'b00;
    end else begin
      if (set_start)      start_q <= 1'b1;
      else if (handshake) start_q <= auto_q;
      if (wr_ctrl) auto_q <= w_byte_q[7];
      if (wr_lo && aw_idx_q == W_GIE) gie_q <= w_byte_q[0];
      if (wr_lo && aw_idx_q == W_IER) ier_q <= w_byte_q[1:0];
    end
  end

  // read channel
  logic [IDX_W-1:0] rd_idx;
  logic ar_fire, done_clr;
  assign rd_idx    = s_araddr[ADDR_W-1:2];
  assign s_arready = ~rvalid_q;
  assign ar_fire   = s_arvalid & s_arready;
  assign done_clr  = ar_fire && (rd_idx == W_CTRL) && done_q;
  assign s_rvalid  = rvalid_q;
  assign s_rdata   = rdata_q;
  assign s_rresp   = 2'b00;

  always_comb begin
    rd_mux = '0;
    case (rd_idx)
      W_CTRL: begin
        rd_mux[0] = start_q;
        rd_mux[1] = done_q;
        rd_mux[2] = eng_idle;
        rd_mux[3] = eng_ready;
        rd_mux[7] = auto_q;
      end
      W_GIE:   rd_mux[0]   = gie_q;
      W_IER:   rd_mux[1:0] = ier_q;
      W_ISR:   rd_mux      = '0;
      default: rd_mux      = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      if (ar_fire) begin
        rvalid_q <= 1'b1;
        rdata_q  <= rd_mux;
      end else if (rvalid_q && s_rready) begin
        rvalid_q <= 1'b0;
      end
      if (eng_done)      done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
    end
  end

  // assertions
  p_start_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_start |=> start_q);
  p_start_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    handshake && !auto_q && !set_start |=> !start_q);
  p_start_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_q) |-> $past(eng_ready));
  p_auto_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    handshake && auto_q |=> start_q);
  p_done_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> done_q);
  p_done_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_clr && !eng_done |=> !done_q);
  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !done_clr |=> done_q);
  p_inert_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo && aw_idx_q != W_CTRL && !handshake |=> $stable(start_q));
  p_resv_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> s_rdata[DATA_W-1:8] == '0);
  p_rhold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
  p_bhold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid);

endmodule

// File: tb/sim_accel_ctrl_regs.sv
module sim_accel_ctrl_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [5:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic        eng_start;
  logic        eng_done = 0, eng_idle = 0, eng_ready = 0;

  int n_tests = 0, n_fail = 0;
  logic [31:0] d;

  accel_ctrl_regs u0 (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .eng_start(eng_start), .eng_done(eng_done), .eng_idle(eng_idle), .eng_ready(eng_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] v, input logic [3:0] s);
    @(negedge clk);
    awaddr = a; wdata = v; wstrb = s; awvalid = 1; wvalid = 1; bready = 1;
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    @(negedge clk);
    chk("R10 bvalid", {31'b0, bvalid}, 1);
    chk("R10 bresp", {30'b0, bresp}, 0);
  endtask

  task automatic rd(input logic [5:0] a, input int hold, input logic pulse, output logic [31:0] v);
    @(negedge clk);
    araddr = a; arvalid = 1; rready = (hold == 0); eng_done = pulse;
    @(negedge clk);
    arvalid = 0; eng_done = 0;
    v = rdata;
    chk("R10 rvalid", {31'b0, rvalid}, 1);
    chk("R10 rresp", {30'b0, rresp}, 0);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R10 rvalid held", {31'b0, rvalid}, 1);
      chk("R10 rdata held", rdata, v);
      chk("R10 arready low", {31'b0, arready}, 0);
    end
    rready = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 eng_start", {31'b0, eng_start}, 0);
    chk("R1 readies", {29'b0, awready, wready, arready}, 3'b111);
    chk("R1 valids", {30'b0, bvalid, rvalid}, 0);
    eng_idle = 1;
    rd(6'h00, 0, 0, d); chk("R1 ctrl after reset", d, 32'h4);
    rd(6'h04, 0, 0, d); chk("R1 gie after reset", d, 0);
    rd(6'h08, 0, 0, d); chk("R1 ier after reset", d, 0);
    rd(6'h0C, 0, 0, d); chk("R1 isr after reset", d, 0);

    // R7 idle/ready sweep (no start pending, so no handshake)
    for (int k = 0; k < 4; k++) begin
      eng_idle = k[0]; eng_ready = k[1];
      rd(6'h00, 0, 0, d);
      chk("R7 live bits", d, (32'(k[0]) << 2) | (32'(k[1]) << 3));
    end
    eng_idle = 0; eng_ready = 0;

    // R2 start write
    wr(6'h00, 32'h1, 4'hF);
    chk("R2 eng_start set", {31'b0, eng_start}, 1);
    rd(6'h00, 0, 0, d); chk("R2 ctrl readback", d, 32'h1);
    wr(6'h00, 32'h0, 4'hF);
    chk("R2 write 0 keeps start", {31'b0, eng_start}, 1);

    // R3 handshake without auto-restart
    @(negedge clk); eng_ready = 1;
    @(negedge clk);
    chk("R3 start dropped", {31'b0, eng_start}, 0);
    eng_ready = 0;
    rd(6'h00, 0, 0, d); chk("R3 ctrl after handshake", d, 0);

    // R5/R6 done set and clear on read
    @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0;
    rd(6'h00, 0, 0, d); chk("R5 done set", d, 32'h2);
    rd(6'h00, 0, 0, d); chk("R6 done cleared", d, 0);
    // R6 collision
    @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0;
    rd(6'h00, 0, 1, d); chk("R6 collision read", d, 32'h2);
    rd(6'h00, 0, 0, d); chk("R6 flag kept on collision", d, 32'h2);
    rd(6'h00, 0, 0, d); chk("R6 cleared after", d, 0);

    // R4 auto-restart
    wr(6'h00, 32'h81, 4'h1);
    chk("R4 start set", {31'b0, eng_start}, 1);
    rd(6'h00, 0, 0, d); chk("R4 ctrl readback", d, 32'h81);
    eng_ready = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R4 start held through handshakes", {31'b0, eng_start}, 1);
    end
    eng_ready = 0;
    wr(6'h00, 32'h0, 4'h1);
    chk("R4 start kept after auto cleared", {31'b0, eng_start}, 1);
    rd(6'h00, 0, 0, d); chk("R4 auto cleared readback", d, 32'h1);
    @(negedge clk); eng_ready = 1;
    @(negedge clk);
    chk("R4 next handshake drops start", {31'b0, eng_start}, 0);
    eng_ready = 0;

    // R11 clear strobe
    wr(6'h00, 32'h81, 4'hE);
    chk("R11 strobe low no start", {31'b0, eng_start}, 0);
    rd(6'h00, 0, 0, d); chk("R11 ctrl unchanged", d, 0);

    // R8 inert interrupt registers
    for (int v = 0; v < 4; v++) begin
      wr(6'h04, 32'hFFFF_FFF0 | 32'(v), 4'hF);
      rd(6'h04, 0, 0, d); chk("R8 gie readback", d, 32'(v) & 32'h1);
      wr(6'h08, 32'hFFFF_FFF0 | 32'(v), 4'hF);
      rd(6'h08, 0, 0, d); chk("R8 ier readback", d, 32'(v) & 32'h3);
      chk("R8 no start", {31'b0, eng_start}, 0);
    end
    wr(6'h0C, 32'hFFFF_FFFF, 4'hF);
    rd(6'h0C, 0, 0, d); chk("R8 isr reads zero", d, 0);
    chk("R8 no start after isr write", {31'b0, eng_start}, 0);

    // R9 reserved bits and unmapped offsets
    wr(6'h00, 32'hFFFF_FF7E, 4'hF);
    eng_idle = 1; eng_ready = 1;
    rd(6'h00, 0, 0, d); chk("R9 ctrl reserved zero", d, 32'hC);
    eng_idle = 0; eng_ready = 0;
    for (int a = 16; a < 64; a += 4) begin
      rd(6'(a), 0, 0, d); chk("R9 unmapped zero", d, 0);
    end

    // R10 read held while rready low
    wr(6'h04, 32'h1, 4'h1);
    rd(6'h04, 3, 0, d); chk("R10 held data value", d, 32'h1);
    @(negedge clk);
    chk("R10 rvalid released", {31'b0, rvalid}, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule